// File: doc/BRIEF.md
# Parallel camera input formatter

This block sits at the edge of an image pipeline and takes the pixel bus and the line, frame and field sync signals of a parallel image sensor. It turns them into one internal stream of 16-bit words. Each word comes with a valid strobe, a start-of-frame flag and a start-of-line flag. Raw sensor samples of 8 to 12 bits are zero-extended into the word. 8-bit YCbCr can either be paired into 16-bit words by a byte bridge or passed on one sample per word, with the luma byte put in a fixed lane. Each sync input has its own polarity. The data bus can be inverted bit for bit. The sampling edge of the pixel clock can be chosen. For interlaced sensors an odd/even field flag is reported.

The configuration inputs are static. Every setting except the frame-sync polarity and the sampling edge is taken into the block only at the active edge of the frame sync. A frame that is already running is therefore never reformatted halfway. Crossing into another clock domain and any later processing are outside the block.

Top module: `cam_fmt_top`

## Requirements
- R1: With input mode code 0 (raw), each accepted sample produces one valid word. The word holds the low N bits of the bus and zeros above them, where size code 0 gives N=8, 1 gives 10, 2 gives 11, and any code from 3 to 7 gives 12.
- R2: When the invert input is 1, every bus bit is complemented before any formatting. When it is 0, data passes through unchanged.
- R3: With input mode code 2 (8-bit YCbCr), each accepted sample produces one word. Samples of a line are numbered from 0. A sample whose index parity equals the Y-position bit is luma and is placed in bits [15:8] with zeros below. Every other sample is chroma and is placed in bits [7:0] with zeros above.
- R4: With input mode code 1 (16-bit YCbCr) and bridge code 2 or 3, accepted samples are paired from the start of each line. Only the second sample of a pair produces a valid word, so valid never holds two cycles in a row. The first byte of the pair goes to bits [15:8] when (bridge bit 0 XOR Y-position) is 0, and to bits [7:0] otherwise.
- R5: Mode code 1 with bridge code 0 or 1, and mode code 3, produce no valid word.
- R6: Active level is high when a polarity input is 0 and low when it is 1, separately for line sync, frame sync and field. The frame-sync polarity is applied live. The line-sync and field polarities are latched with the other settings.
- R7: A sample is accepted only in a cycle where both the line sync and the frame sync are at their active level.
- R8: The start-of-frame flag is set together with the first valid word after each active edge of the frame sync, and at no other time.
- R9: The start-of-line flag is set together with the first valid word after the line sync has been inactive, and at no other time.
- R10: At each active edge of the frame sync, the field flag takes the normalised field input if interlaced mode is selected, and 0 otherwise. It holds that value until the next such edge.
- R11: Mode, size, bridge, Y-position, invert, line-sync polarity, field polarity and interlace settings take effect at the frame-sync active edge, starting with the sample seen in that cycle. Changes at any other time have no effect until then.
- R12: The sampling-edge input selects rising (0) or falling (1) capture of bus and syncs. The first output reflects a sample two pixel-clock rising edges after it was driven on rising capture, and one rising edge after it on falling capture. This input is only changed while the block is held in reset.
- R13: During reset and right after it, valid, start flags, field flag and data are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Pixel clock |
| arst_n | input | 1 | Asynchronous active-low reset |
| cfg_mode | input | 2 | Input mode: 0 raw, 1 YCbCr bridged to 16 bits, 2 YCbCr 8-bit, 3 unused |
| cfg_size | input | 3 | Raw sample width code |
| cfg_bridge | input | 2 | Byte bridge enable and byte mapping |
| cfg_ypos | input | 1 | Luma position in the byte sequence |
| cfg_invert | input | 1 | Complement all data bits |
| cfg_hs_neg | input | 1 | Line sync active low |
| cfg_vs_neg | input | 1 | Frame sync active low |
| cfg_fld_neg | input | 1 | Field input active low |
| cfg_interlace | input | 1 | Interlaced sensor |
| cfg_clk_fall | input | 1 | Capture on falling pixel-clock edge |
| sen_data | input | BUS_W (12) | Sensor data bus |
| sen_hsync | input | 1 | Sensor line sync |
| sen_vsync | input | 1 | Sensor frame sync |
| sen_field | input | 1 | Sensor field indicator |
| pix_valid | output | 1 | Output word valid |
| pix_data | output | 16 | Output pixel word |
| pix_sof | output | 1 | First word of a frame |
| pix_sol | output | 1 | First word of a line |
| field_odd | output | 1 | Current field is odd |

## Verification
The bench builds the block with its default 12-bit bus. All four raw width codes can therefore be told apart, including the 12-bit code, where the top output nibble must stay clear. It runs the whole mode, polarity, field and mid-frame reconfiguration sequence once with rising-edge capture. It then resets the block and repeats part of the sequence with falling-edge capture, so both capture latencies are compared against the reference model.

// File: rtl/cam_fmt_pkg.sv
package cam_fmt_pkg;

  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    IM_RAW  = 2'd0,
    IM_YC16 = 2'd1,
    IM_YC8  = 2'd2,
    IM_RSVD = 2'd3
  } in_mode_e;

  typedef struct packed {
    in_mode_e    mode;
    logic [2:0]  size;
    logic [1:0]  bridge;
    logic        ypos;
    logic        inv;
    logic        hs_neg;
    logic        fld_neg;
    logic        interlace;
  } fmt_cfg_t;

  // width in bits selected by a raw size code
  function automatic int raw_width(input logic [2:0] code);
    case (code)
      3'd0:    return 8;
      3'd1:    return 10;
      3'd2:    return 11;
      default: return 12;
    endcase
  endfunction

endpackage

// File: rtl/cam_fmt_capture.sv
module cam_fmt_capture #(
  parameter int BUS_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fall_sel,
  input  logic [BUS_W-1:0] d_in,
  input  logic             hs_in,
  input  logic             vs_in,
  input  logic             fld_in,
  output logic [BUS_W-1:0] d_o,
  output logic             hs_o,
  output logic             vs_o,
  output logic             fld_o
);

  localparam int CAP_W = BUS_W + 3;

  logic [CAP_W-1:0] bus_now;
  logic [CAP_W-1:0] rise_q;
  logic [CAP_W-1:0] fall_q;
  logic [CAP_W-1:0] pick;

  assign bus_now = {fld_in, vs_in, hs_in, d_in};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rise_q <= '0;
    else        rise_q <= bus_now;
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) fall_q <= '0;
    else        fall_q <= bus_now;
  end

  always_comb begin
    pick  = fall_sel ? fall_q : rise_q;
    d_o   = pick[BUS_W-1:0];
    hs_o  = pick[BUS_W];
    vs_o  = pick[BUS_W+1];
    fld_o = pick[BUS_W+2];
  end

endmodule

// File: rtl/cam_fmt_timing.sv
module cam_fmt_timing
  import cam_fmt_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  fmt_cfg_t   cfg_in,
  input  logic       vs_neg,
  input  logic       raw_hs,
  input  logic       raw_vs,
  input  logic       raw_fld,
  output fmt_cfg_t   eff_o,
  output logic       frame_edge_o,
  output logic       line_act_o,
  output logic       take_o,
  output in_mode_e   act_mode_o,
  output logic [1:0] act_bridge_o,
  output logic       field_odd_o
);

  logic     vs_now;
  logic     vs_q;
  logic     fld_now;
  fmt_cfg_t act_q;
  logic     odd_q;
  logic     odd_d;

  always_comb begin
    vs_now       = raw_vs ^ vs_neg;
    frame_edge_o = vs_now & ~vs_q;
    eff_o        = frame_edge_o ? cfg_in : act_q;
    line_act_o   = raw_hs ^ eff_o.hs_neg;
    fld_now      = raw_fld ^ eff_o.fld_neg;
    take_o       = line_act_o & vs_now;
    odd_d        = frame_edge_o ? (eff_o.interlace & fld_now) : odd_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vs_q  <= 1'b0;
      act_q <= '0;
      odd_q <= 1'b0;
    end else begin
      vs_q  <= vs_now;
      odd_q <= odd_d;
      if (frame_edge_o) act_q <= cfg_in;
    end
  end

  assign act_mode_o   = act_q.mode;
  assign act_bridge_o = act_q.bridge;
  assign field_odd_o  = odd_q;

  // R10
  prog_field_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !act_q.interlace |-> !odd_q);

  // R11
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_edge_o |=> $stable(act_q));

endmodule

// File: rtl/cam_fmt_pack.sv
module cam_fmt_pack
  import cam_fmt_pkg::*;
#(
  parameter int BUS_W = 12
) (
  input  logic                clk,
  input  logic                rst_n,
  input  in_mode_e            mode,
  input  logic [2:0]          size,
  input  logic [1:0]          bridge,
  input  logic                ypos,
  input  logic                inv,
  input  logic                frame_edge,
  input  logic                line_act,
  input  logic                take,
  input  logic [BUS_W-1:0]    din,
  output logic                valid_o,
  output logic [2*BYTE_W-1:0] data_o,
  output logic                sof_o,
  output logic                sol_o
);

  localparam int OUT_W = 2 * BYTE_W;

  logic [BUS_W-1:0]  dinv;
  logic [BUS_W-1:0]  mask;
  logic [BUS_W-1:0]  raw_m;
  logic [OUT_W-1:0]  raw_word;
  logic [BYTE_W-1:0] cur_b;

  logic              phase_q, phase_d;
  logic [BYTE_W-1:0] held_q;
  logic              held_en;
  logic              sofp_q, sofp_d;
  logic              solp_q, solp_d;
  logic              vld_d, sof_d, sol_d;
  logic [OUT_W-1:0]  word_d;
  logic              luma, first_hi;

  always_comb begin
    dinv = din ^ {BUS_W{inv}};
    for (int i = 0; i < BUS_W; i++) mask[i] = (i < raw_width(size));
    raw_m = dinv & mask;
    cur_b = dinv[BYTE_W-1:0];
  end

  generate
    if (BUS_W < OUT_W) begin : g_pad
      assign raw_word = {{(OUT_W-BUS_W){1'b0}}, raw_m};
    end else begin : g_trim
      assign raw_word = raw_m[OUT_W-1:0];
    end
  endgenerate

  // next state
  always_comb begin
    luma     = (phase_q == ypos);
    first_hi = ~(bridge[0] ^ ypos);
    vld_d    = 1'b0;
    word_d   = data_o;
    case (mode)
      IM_RAW: begin
        vld_d  = take;
        word_d = raw_word;
      end
      IM_YC8: begin
        vld_d  = take;
        word_d = luma ? {cur_b, {BYTE_W{1'b0}}} : {{BYTE_W{1'b0}}, cur_b};
      end
      IM_YC16: begin
        vld_d  = take & phase_q & bridge[1];
        word_d = first_hi ? {held_q, cur_b} : {cur_b, held_q};
      end
      default: vld_d = 1'b0;
    endcase
    phase_d = take ? ~phase_q : 1'b0;
    held_en = take & ~phase_q;
    sof_d   = vld_d & (sofp_q | frame_edge);
    sol_d   = vld_d & solp_q;
    if (frame_edge)  sofp_d = ~vld_d;
    else if (vld_d)  sofp_d = 1'b0;
    else             sofp_d = sofp_q;
    if (!line_act)   solp_d = 1'b1;
    else if (vld_d)  solp_d = 1'b0;
    else             solp_d = solp_q;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= 1'b0;
      held_q  <= '0;
      sofp_q  <= 1'b0;
      solp_q  <= 1'b1;
      valid_o <= 1'b0;
      data_o  <= '0;
      sof_o   <= 1'b0;
      sol_o   <= 1'b0;
    end else begin
      phase_q <= phase_d;
      sofp_q  <= sofp_d;
      solp_q  <= solp_d;
      valid_o <= vld_d;
      sof_o   <= sof_d;
      sol_o   <= sol_d;
      if (held_en) held_q <= cur_b;
      if (vld_d)   data_o <= word_d;
    end
  end

  // R8
  sof_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sof_o |-> valid_o);

  // R9
  sol_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sol_o |-> valid_o);

endmodule

// File: rtl/cam_fmt_top.sv
module cam_fmt_top
  import cam_fmt_pkg::*;
#(
  parameter int BUS_W = 12
) (
  input  logic             pclk,
  input  logic             arst_n,
  input  logic [1:0]       cfg_mode,
  input  logic [2:0]       cfg_size,
  input  logic [1:0]       cfg_bridge,
  input  logic             cfg_ypos,
  input  logic             cfg_invert,
  input  logic             cfg_hs_neg,
  input  logic             cfg_vs_neg,
  input  logic             cfg_fld_neg,
  input  logic             cfg_interlace,
  input  logic             cfg_clk_fall,
  input  logic [BUS_W-1:0] sen_data,
  input  logic             sen_hsync,
  input  logic             sen_vsync,
  input  logic             sen_field,
  output logic             pix_valid,
  output logic [15:0]      pix_data,
  output logic             pix_sof,
  output logic             pix_sol,
  output logic             field_odd
);

  logic             rst_meta, rst_sync;
  fmt_cfg_t         cfg_live;
  fmt_cfg_t         eff;
  logic [BUS_W-1:0] c_d;
  logic             c_hs, c_vs, c_fld;
  logic             f_edge, l_act, take;
  in_mode_e         act_mode;
  logic [1:0]       act_bridge;

  // asynchronous assert, synchronous release
  always_ff @(posedge pclk or negedge arst_n) begin
    if (!arst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  always_comb begin
    cfg_live.mode      = in_mode_e'(cfg_mode);
    cfg_live.size      = cfg_size;
    cfg_live.bridge    = cfg_bridge;
    cfg_live.ypos      = cfg_ypos;
    cfg_live.inv       = cfg_invert;
    cfg_live.hs_neg    = cfg_hs_neg;
    cfg_live.fld_neg   = cfg_fld_neg;
    cfg_live.interlace = cfg_interlace;
  end

  cam_fmt_capture #(.BUS_W(BUS_W)) u_cap (
    .clk(pclk), .rst_n(rst_sync), .fall_sel(cfg_clk_fall),
    .d_in(sen_data), .hs_in(sen_hsync), .vs_in(sen_vsync), .fld_in(sen_field),
    .d_o(c_d), .hs_o(c_hs), .vs_o(c_vs), .fld_o(c_fld)
  );

  cam_fmt_timing u_tim (
    .clk(pclk), .rst_n(rst_sync), .cfg_in(cfg_live), .vs_neg(cfg_vs_neg),
    .raw_hs(c_hs), .raw_vs(c_vs), .raw_fld(c_fld),
    .eff_o(eff), .frame_edge_o(f_edge), .line_act_o(l_act), .take_o(take),
    .act_mode_o(act_mode), .act_bridge_o(act_bridge), .field_odd_o(field_odd)
  );

  cam_fmt_pack #(.BUS_W(BUS_W)) u_pack (
    .clk(pclk), .rst_n(rst_sync),
    .mode(eff.mode), .size(eff.size), .bridge(eff.bridge), .ypos(eff.ypos), .inv(eff.inv),
    .frame_edge(f_edge), .line_act(l_act), .take(take), .din(c_d),
    .valid_o(pix_valid), .data_o(pix_data), .sof_o(pix_sof), .sol_o(pix_sol)
  );

  // R1
  raw_msb_chk: assert property (@(posedge pclk) disable iff (!rst_sync)
    (pix_valid && act_mode == IM_RAW) |-> (pix_data[15:12] == 4'h0));

  // R5
  no_output_chk: assert property (@(posedge pclk) disable iff (!rst_sync)
    pix_valid |-> !(act_mode == IM_RSVD || (act_mode == IM_YC16 && !act_bridge[1])));

  // R4
  pair_rate_chk: assert property (@(posedge pclk) disable iff (!rst_sync)
    (pix_valid && act_mode == IM_YC16) |=> !pix_valid);

endmodule

// File: tb/tb_cam_fmt_top.sv
`timescale 1ns/1ps
module tb_cam_fmt_top;

  logic        pclk = 1'b0;
  logic        arst_n;
  logic [1:0]  cfg_mode;
  logic [2:0]  cfg_size;
  logic [1:0]  cfg_bridge;
  logic        cfg_ypos, cfg_invert, cfg_hs_neg, cfg_vs_neg, cfg_fld_neg;
  logic        cfg_interlace, cfg_clk_fall;
  logic [11:0] sen_data;
  logic        sen_hsync, sen_vsync, sen_field;
  logic        pix_valid, pix_sof, pix_sol, field_odd;
  logic [15:0] pix_data;

  always #2.5 pclk = ~pclk;

  cam_fmt_top dut (.*);

  int    checks = 0;
  int    errors = 0;
  bit    run = 0;
  string cur_req = "R13";
  logic [14:0] hq[$];

  // reference model state
  bit m_vs, m_field, m_sofp, m_solp, m_phase;
  bit [7:0]  m_held;
  bit [1:0]  a_mode; bit [2:0] a_size; bit [1:0] a_bridge;
  bit a_ypos, a_inv, a_hsn, a_fldn, a_il;
  bit e_valid, e_sof, e_sol;
  bit [15:0] e_data;

  task automatic model_reset();
    m_vs = 0; m_field = 0; m_sofp = 0; m_solp = 1; m_phase = 0; m_held = 0;
    a_mode = 0; a_size = 0; a_bridge = 0; a_ypos = 0; a_inv = 0; a_hsn = 0; a_fldn = 0; a_il = 0;
    e_valid = 0; e_sof = 0; e_sol = 0; e_data = 0;
  endtask

  task automatic model_step();
    int lat = cfg_clk_fall ? 1 : 2;
    logic [14:0] s = hq[hq.size()-lat];
    bit vsn, rise, hsn, fn, acc, v, lum;
    bit [11:0] dd;
    bit [15:0] w;
    int wid;
    vsn = s[13] ^ cfg_vs_neg;
    rise = vsn && !m_vs;
    if (rise) begin
      a_mode = cfg_mode; a_size = cfg_size; a_bridge = cfg_bridge; a_ypos = cfg_ypos;
      a_inv = cfg_invert; a_hsn = cfg_hs_neg; a_fldn = cfg_fld_neg; a_il = cfg_interlace;
    end
    hsn = s[12] ^ a_hsn;
    fn  = s[14] ^ a_fldn;
    acc = hsn && vsn;
    if (rise) m_field = a_il ? fn : 0;
    dd = s[11:0] ^ (a_inv ? 12'hFFF : 12'h000);
    v = 0; w = e_data;
    case (a_mode)
      2'd0: begin
        v = acc;
        wid = (a_size == 0) ? 8 : (a_size == 1) ? 10 : (a_size == 2) ? 11 : 12;
        w = 16'(dd % (1 << wid));
      end
      2'd2: begin
        v = acc;
        lum = (m_phase == a_ypos);
        w = lum ? {dd[7:0], 8'h00} : {8'h00, dd[7:0]};
      end
      2'd1: begin
        v = acc && m_phase && a_bridge[1];
        w = ((a_bridge[0] ^ a_ypos) == 0) ? {m_held, dd[7:0]} : {dd[7:0], m_held};
      end
      default: v = 0;
    endcase
    e_sof = v && (m_sofp || rise);
    e_sol = v && m_solp;
    m_sofp = rise ? !v : (v ? 0 : m_sofp);
    m_solp = !hsn ? 1 : (v ? 0 : m_solp);
    if (acc && !m_phase) m_held = dd[7:0];
    m_phase = acc ? !m_phase : 0;
    m_vs = vsn;
    e_valid = v;
    if (v) e_data = w;
  endtask

  task automatic chk(string nm, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s got %0h exp %0h", cur_req, nm, act, exp);
    end
  endtask

  task automatic compare();
    chk("valid", 16'(pix_valid), 16'(e_valid));
    chk("data", pix_data, e_data);
    chk("sof", 16'(pix_sof), 16'(e_sof));
    chk("sol", 16'(pix_sol), 16'(e_sol));
    chk("field", 16'(field_odd), 16'(m_field));
  endtask

  // one pixel clock: arguments are active levels
  task automatic cyc(bit h, bit v, bit f, logic [11:0] d);
    @(posedge pclk);
    if (run) model_step();
    #1;
    sen_hsync = h ^ cfg_hs_neg;
    sen_vsync = v ^ cfg_vs_neg;
    sen_field = f ^ cfg_fld_neg;
    sen_data  = d;
    hq.push_back({sen_field, sen_vsync, sen_hsync, sen_data});
    if (hq.size() > 4) void'(hq.pop_front());
    #2;
    if (run) compare();
  endtask

  task automatic frame(int nl, int np, bit f, bit pre, int seed, bit mid);
    if (pre) for (int p = 0; p < np; p++) cyc(1, 0, f, 12'(seed + p));
    repeat (2) cyc(0, 0, f, 0);
    repeat (2) cyc(0, 1, f, 0);
    for (int l = 0; l < nl; l++) begin
      for (int p = 0; p < np; p++) cyc(1, 1, f, 12'(seed + p * 37 + l * 101 + 12'hA50));
      repeat (2) cyc(0, 1, f, 0);
      if (mid && l == 0) begin
        cfg_mode = 2'd2; cfg_invert = ~cfg_invert; cfg_size = 3'd0;
      end
    end
    repeat (2) cyc(0, 0, f, 0);
  endtask

  task automatic do_reset(bit fall);
    run = 0;
    cur_req = "R13";
    arst_n = 0;
    cfg_mode = 0; cfg_size = 0; cfg_bridge = 0; cfg_ypos = 0; cfg_invert = 0;
    cfg_hs_neg = 0; cfg_vs_neg = 0; cfg_fld_neg = 0; cfg_interlace = 0; cfg_clk_fall = fall;
    sen_data = 0; sen_hsync = 0; sen_vsync = 0; sen_field = 0;
    repeat (3) @(posedge pclk);
    #3;
    model_reset();
    compare();
    @(negedge pclk);
    arst_n = 1;
    repeat (6) cyc(0, 0, 0, 0);
    model_reset();
    run = 1;
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog expired got 0 exp 1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    do_reset(0);
    // R1 raw widths
    cur_req = "R1";
    for (int c = 0; c < 5; c++) begin
      cfg_size = 3'(c);
      frame(2, 6, 0, 0, 12'hF3C + c, 0);
    end
    // R2 inversion
    cur_req = "R2";
    cfg_size = 3'd3; cfg_invert = 1;
    frame(2, 5, 0, 0, 12'h123, 0);
    cfg_size = 3'd1;
    frame(1, 5, 0, 0, 12'h0F0, 0);
    cfg_invert = 0;
    // R3 8-bit YCbCr
    cur_req = "R3";
    cfg_mode = 2'd2;
    for (int y = 0; y < 2; y++) begin
      cfg_ypos = y[0];
      frame(2, 7, 0, 0, 12'h3A1, 0);
    end
    // R4 bridged 16-bit YCbCr
    cur_req = "R4";
    cfg_mode = 2'd1;
    for (int b = 2; b < 4; b++)
      for (int y = 0; y < 2; y++) begin
        cfg_bridge = 2'(b); cfg_ypos = y[0];
        frame(2, 8, 0, 0, 12'h5C7 + b, 0);
      end
    // R5 no output
    cur_req = "R5";
    cfg_bridge = 2'd1;
    frame(1, 6, 0, 0, 12'h111, 0);
    cfg_bridge = 2'd0;
    frame(1, 6, 0, 0, 12'h222, 0);
    cfg_mode = 2'd3;
    frame(1, 6, 0, 0, 12'h333, 0);
    cfg_mode = 2'd0; cfg_bridge = 2'd0; cfg_ypos = 0;
    // R6 polarities
    cur_req = "R6";
    cfg_hs_neg = 1;
    frame(2, 5, 0, 0, 12'h777, 0);
    cfg_vs_neg = 1;
    frame(2, 5, 0, 0, 12'h888, 0);
    cfg_hs_neg = 0; cfg_vs_neg = 0;
    frame(1, 5, 0, 0, 12'h999, 0);
    // R7 line sync active outside the frame
    cur_req = "R7";
    frame(2, 6, 0, 1, 12'h4B2, 0);
    // R8 R9 several lines of uneven length
    cur_req = "R9";
    frame(4, 3, 0, 0, 12'h0AB, 0);
    cur_req = "R8";
    frame(1, 1, 0, 0, 12'h0CD, 0);
    // R10 field status
    cur_req = "R10";
    frame(1, 4, 1, 0, 12'h010, 0);
    cfg_interlace = 1;
    frame(1, 4, 1, 0, 12'h020, 0);
    frame(1, 4, 0, 0, 12'h030, 0);
    cfg_fld_neg = 1;
    frame(1, 4, 1, 0, 12'h040, 0);
    cfg_interlace = 0; cfg_fld_neg = 0;
    frame(1, 4, 1, 0, 12'h050, 0);
    // R11 mid-frame change ignored until next frame
    cur_req = "R11";
    cfg_mode = 2'd0; cfg_size = 3'd3; cfg_invert = 0;
    frame(3, 6, 0, 0, 12'hE01, 1);
    frame(2, 6, 0, 0, 12'hE02, 0);
    // R12 falling-edge capture
    do_reset(1);
    cur_req = "R12";
    cfg_size = 3'd2;
    frame(2, 6, 0, 0, 12'hB0B, 0);
    cfg_mode = 2'd1; cfg_bridge = 2'd3;
    frame(2, 6, 0, 0, 12'hC0C, 0);
    cfg_mode = 2'd2; cfg_ypos = 1; cfg_hs_neg = 1;
    frame(2, 5, 0, 0, 12'hD0D, 0);
    repeat (3) cyc(0, 0, 0, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule